// File: doc/BRIEF.md
# Oscillator Coarse-Tune Calibrator

This block chooses a coarse-tuning code for a tunable oscillator by measuring frequency. For each candidate code it first waits for the oscillator to settle. It then opens a counting window that lasts a fixed number of reference-clock cycles, and it counts the rising edges of the divided feedback clock during that window. If the feedback count is still larger than the number of reference cycles in the window, the oscillator is too fast. The code is then stepped one position toward lower frequency and the measurement is repeated.

The window length is a parameter given in reference cycles. It should be set to one full period of any spread-spectrum modulation on the reference, for example the reference frequency divided by 33 kHz. The measurement then averages over a whole modulation cycle, and the result does not depend on the modulation phase at which counting began. The feedback counter runs in the feedback domain from a synchronised copy of the window enable. The controller reads that count only after the window has closed and a drain interval has passed, so the count it reads has stopped moving.

Top module: `vco_coarse_cal`

## Requirements
- R1: While `rst_n` is low, `code` is all ones (31 for the default 5-bit width), `done` is 0 and `cal_err` is 0. This also holds when reset is applied in the middle of a search.
- R2: A `start` pulse seen at a rising `ref_clk` edge while the block is idle, including after `done` has been raised, sets `code` to all ones and clears `done` and `cal_err` at that same edge.
- R3: For each candidate code, the block waits `SETTLE_CYC` reference cycles. It then holds its internal window enable high for exactly `WIN_CYC` consecutive reference cycles.
- R4: During a search, `code` changes only by decrementing exactly one step. A higher code value means a higher oscillator frequency.
- R5: The search ends at the first code whose feedback count is less than or equal to `WIN_CYC`. At that point `done` becomes 1, `cal_err` stays 0 and `code` holds the accepted value.
- R6: If code 0 is evaluated and its feedback count still exceeds `WIN_CYC`, the block sets `done` and `cal_err` to 1 and holds `code` at 0. `cal_err` is never 1 while `done` is 0.
- R7: Once `done` is 1, `code`, `done` and `cal_err` stay constant until the next `start`.
- R8: A `start` pulse that arrives while a search is running is ignored. `code` is not reloaded, and the search completes with the same result it would have reached without that pulse.
- R9: The controller samples the feedback count only after the window enable has been low for `DRAIN_CYC` reference cycles. The count is stable at the sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all controller state and all outputs are in this domain |
| fb_clk | input | 1 | Divided feedback clock from the oscillator |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| start | input | 1 | One-cycle pulse in the `ref_clk` domain that begins a search |
| code | output | CODE_W | Coarse-tuning code driven to the oscillator DAC |
| done | output | 1 | Search finished; `code` is final |
| cal_err | output | 1 | No crossing found down to code 0 |

## Verification
Two events can fall on the same decision edge: the frequency crossing and arrival at the last code. The bench provokes this by placing the modelled crossing exactly at code 0, which must end with `done` set and `cal_err` clear. It also places the crossing below code 0, which must raise both flags with the code held at 0. A second overlap is a fresh `start` during an active search. This pulse is issued once the code has already stepped down several positions, and the bench judges it by checking that the code does not return to the top and that the original crossing is still found.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_COUNT  = 2'd2,
    ST_DRAIN  = 2'd3
  } cal_st_e;
endpackage

// File: rtl/cal_rst_sync.sv
// Asserts asynchronously, releases on the second clock edge.
module cal_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      srst_n  <= stage_q;
    end
  end
endmodule

// File: rtl/cal_fb_counter.sv
// Feedback-domain edge counter gated by a synchronised window enable.
// The count restarts on the synchronised rising edge of the enable and
// freezes once the enable falls, so it can be read after a drain delay.
module cal_fb_counter #(
  parameter int CNT_W = 12
) (
  input  logic             fb_clk,
  input  logic             rst_n,
  input  logic             win_en,
  output logic [CNT_W-1:0] fb_cnt
);
  logic [2:0]       en_sh_q;
  logic             en_s, en_d;
  logic [CNT_W-1:0] cnt_n;

  assign en_s = en_sh_q[1];
  assign en_d = en_sh_q[2];

  always_comb begin
    cnt_n = fb_cnt;
    if (en_s && !en_d) begin
      cnt_n = CNT_W'(1);
    end else if (en_s && (fb_cnt != {CNT_W{1'b1}})) begin
      cnt_n = fb_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge fb_clk or negedge rst_n) begin
    if (!rst_n) begin
      en_sh_q <= '0;
      fb_cnt  <= '0;
    end else begin
      en_sh_q <= {en_sh_q[1:0], win_en};
      fb_cnt  <= cnt_n;
    end
  end
endmodule

// File: rtl/cal_ctrl.sv
// Reference-domain search controller: settle, count window, drain, decide.
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int CODE_W     = 5,
  parameter int CNT_W      = 12,
  parameter int SETTLE_CYC = 64,
  parameter int WIN_CYC    = 3030,
  parameter int DRAIN_CYC  = 8
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  fb_cnt,
  output logic [CODE_W-1:0] code,
  output logic              done,
  output logic              cal_err,
  output logic              win_en,
  output logic              take
);
  localparam int TMAX0 = (SETTLE_CYC > WIN_CYC) ? SETTLE_CYC : WIN_CYC;
  localparam int TMAX  = (TMAX0 > DRAIN_CYC) ? TMAX0 : DRAIN_CYC;
  localparam int TMR_W = $clog2(TMAX + 1);
  localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};

  cal_st_e           st_q, st_n;
  logic [TMR_W-1:0]  tmr_q, tmr_n;
  logic [CODE_W-1:0] code_n;
  logic              done_n, err_n, win_n;
  logic              tmr_end, crossed;

  always_comb begin
    unique case (st_q)
      ST_SETTLE: tmr_end = (tmr_q == TMR_W'(SETTLE_CYC - 1));
      ST_COUNT:  tmr_end = (tmr_q == TMR_W'(WIN_CYC - 1));
      ST_DRAIN:  tmr_end = (tmr_q == TMR_W'(DRAIN_CYC - 1));
      default:   tmr_end = 1'b0;
    endcase
  end

  assign take    = (st_q == ST_DRAIN) && tmr_end;
  assign crossed = (fb_cnt <= CNT_W'(WIN_CYC));

  always_comb begin
    st_n   = st_q;
    tmr_n  = tmr_q;
    code_n = code;
    done_n = done;
    err_n  = cal_err;
    win_n  = win_en;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_n   = ST_SETTLE;
          tmr_n  = '0;
          code_n = CODE_TOP;
          done_n = 1'b0;
          err_n  = 1'b0;
        end
      end
      ST_SETTLE: begin
        tmr_n = tmr_q + TMR_W'(1);
        if (tmr_end) begin
          st_n  = ST_COUNT;
          tmr_n = '0;
          win_n = 1'b1;
        end
      end
      ST_COUNT: begin
        tmr_n = tmr_q + TMR_W'(1);
        if (tmr_end) begin
          st_n  = ST_DRAIN;
          tmr_n = '0;
          win_n = 1'b0;
        end
      end
      ST_DRAIN: begin
        tmr_n = tmr_q + TMR_W'(1);
        if (tmr_end) begin
          tmr_n = '0;
          if (crossed) begin
            st_n   = ST_IDLE;
            done_n = 1'b1;
          end else if (code == '0) begin
            st_n   = ST_IDLE;
            done_n = 1'b1;
            err_n  = 1'b1;
          end else begin
            st_n   = ST_SETTLE;
            code_n = code - CODE_W'(1);
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      tmr_q   <= '0;
      code    <= CODE_TOP;
      done    <= 1'b0;
      cal_err <= 1'b0;
      win_en  <= 1'b0;
    end else begin
      st_q    <= st_n;
      tmr_q   <= tmr_n;
      code    <= code_n;
      done    <= done_n;
      cal_err <= err_n;
      win_en  <= win_n;
    end
  end
endmodule

// File: rtl/vco_coarse_cal.sv
module vco_coarse_cal #(
  parameter int CODE_W     = 5,
  parameter int SETTLE_CYC = 64,
  parameter int WIN_CYC    = 3030,
  parameter int DRAIN_CYC  = 8
) (
  input  logic              ref_clk,
  input  logic              fb_clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [CODE_W-1:0] code,
  output logic              done,
  output logic              cal_err
);
  // Headroom for a feedback clock up to about 8x the reference.
  localparam int CNT_W = $clog2(WIN_CYC + 1) + 3;

  logic             ref_rst_n, fb_rst_n;
  logic             win_en, take;
  logic [CNT_W-1:0] fb_cnt;

  cal_rst_sync u_rs_ref (.clk(ref_clk), .arst_n(rst_n), .srst_n(ref_rst_n));
  cal_rst_sync u_rs_fb  (.clk(fb_clk),  .arst_n(rst_n), .srst_n(fb_rst_n));

  cal_fb_counter #(.CNT_W(CNT_W)) u_fbc (
    .fb_clk (fb_clk),
    .rst_n  (fb_rst_n),
    .win_en (win_en),
    .fb_cnt (fb_cnt)
  );

  cal_ctrl #(
    .CODE_W     (CODE_W),
    .CNT_W      (CNT_W),
    .SETTLE_CYC (SETTLE_CYC),
    .WIN_CYC    (WIN_CYC),
    .DRAIN_CYC  (DRAIN_CYC)
  ) u_ctl (
    .ref_clk (ref_clk),
    .rst_n   (ref_rst_n),
    .start   (start),
    .fb_cnt  (fb_cnt),
    .code    (code),
    .done    (done),
    .cal_err (cal_err),
    .win_en  (win_en),
    .take    (take)
  );
endmodule

// File: rtl/cal_checker.sv
module cal_checker #(
  parameter int CODE_W  = 5,
  parameter int CNT_W   = 12,
  parameter int WIN_CYC = 3030
) (
  input logic              ref_clk,
  input logic              rst_n,
  input logic              start,
  input logic [CODE_W-1:0] code,
  input logic              done,
  input logic              cal_err,
  input logic              win_en,
  input logic              take,
  input logic [CNT_W-1:0]  fb_cnt
);
  int wcnt;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)      wcnt <= 0;
    else if (win_en) wcnt <= wcnt + 1;
    else             wcnt <= 0;
  end

  p_start_clears_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (start && (done || (code == {CODE_W{1'b1}}))) |=> (!done && !cal_err && (code == {CODE_W{1'b1}})));

  p_window_len_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(win_en) |-> (wcnt == WIN_CYC));

  p_step_down_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!$past(start) && (code != $past(code))) |-> (code == $past(code) - CODE_W'(1)));

  p_err_needs_done_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    cal_err |-> done);

  p_err_at_floor_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    cal_err |-> (code == '0));

  p_hold_result_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(code) && $stable(cal_err)));

  p_read_quiet_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    take |-> (!win_en && $stable(fb_cnt)));
endmodule

bind vco_coarse_cal cal_checker #(
  .CODE_W  (CODE_W),
  .CNT_W   (CNT_W),
  .WIN_CYC (WIN_CYC)
) u_chk (
  .ref_clk (ref_clk),
  .rst_n   (rst_n),
  .start   (start),
  .code    (code),
  .done    (done),
  .cal_err (cal_err),
  .win_en  (win_en),
  .take    (take),
  .fb_cnt  (fb_cnt)
);

// File: tb/sim_vco_coarse_cal.sv
`timescale 1ps/1ps
module sim_vco_coarse_cal;
  localparam int CLK_PERIOD = 10000;
  localparam int CODE_W     = 5;
  localparam int WIN        = 200;
  localparam int NVEC       = 5;
  // Crossing code of the oscillator model and the expected outcome.
  localparam int VEC_X[NVEC]    = '{31, 20, 5, 0, -1};
  localparam int VEC_CODE[NVEC] = '{31, 20, 5, 0, 0};
  localparam int VEC_ERR[NVEC]  = '{0, 0, 0, 0, 1};

  logic              ref_clk, fb_clk, rst_n, start;
  logic [CODE_W-1:0] code;
  logic              done, cal_err;

  int n_run  = 0;
  int n_fail = 0;
  int xsel   = 31;
  int hp_ps;

  vco_coarse_cal #(
    .CODE_W(CODE_W), .SETTLE_CYC(8), .WIN_CYC(WIN), .DRAIN_CYC(8)
  ) u0 (
    .ref_clk(ref_clk), .fb_clk(fb_clk), .rst_n(rst_n), .start(start),
    .code(code), .done(done), .cal_err(cal_err)
  );

  // Oscillator model: 2% period change per code step. The code at xsel
  // gives 198 counts per window; the code one above gives 202.
  always_comb hp_ps = 5050 + 100 * (xsel - int'(code));

  initial ref_clk = 1'b0;
  always #(CLK_PERIOD / 2) ref_clk = ~ref_clk;

  initial fb_clk = 1'b0;
  always begin
    #((hp_ps > 0) ? hp_ps : 5000);
    fb_clk = ~fb_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge ref_clk);
    start = 1'b1;
    @(negedge ref_clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge ref_clk);
      n++;
    end
    chk(done == 1'b1, req, int'(done), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    repeat (5) @(negedge ref_clk);
    // R1: reset values
    chk(code == 5'd31, "R1 code", int'(code), 31);
    chk(done == 1'b0,  "R1 done", int'(done), 0);
    chk(cal_err == 1'b0, "R1 err", int'(cal_err), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge ref_clk);

    // R5 / R6: table of crossing positions
    for (int i = 0; i < NVEC; i++) begin
      xsel = VEC_X[i];
      pulse_start();
      // R2: start from idle/done clears flags and reloads the top code
      chk(done == 1'b0 && cal_err == 1'b0 && code == 5'd31 || VEC_CODE[i] == 31,
          "R2 restart", int'(done), 0);
      wait_done("R5 done");
      @(negedge ref_clk);
      chk(int'(code) == VEC_CODE[i], "R5/R6 code", int'(code), VEC_CODE[i]);
      chk(int'(cal_err) == VEC_ERR[i], "R6 err", int'(cal_err), VEC_ERR[i]);
    end

    // R7: result held while idle
    repeat (300) @(negedge ref_clk);
    chk(done == 1'b1 && code == 5'd0, "R7 hold code", int'(code), 0);
    chk(cal_err == 1'b1, "R7 hold err", int'(cal_err), 1);

    // R2: restart after an error result
    xsel = 12;
    pulse_start();
    chk(done == 1'b0, "R2 done clr", int'(done), 0);
    chk(cal_err == 1'b0, "R2 err clr", int'(cal_err), 0);
    chk(code == 5'd31, "R2 code top", int'(code), 31);
    wait_done("R4 done");
    @(negedge ref_clk);
    chk(code == 5'd12, "R4 stepped search", int'(code), 12);

    // R8: start while busy is ignored
    xsel = 20;
    pulse_start();
    begin
      int n = 0;
      while (code != 5'd25 && n < 20000) begin
        @(negedge ref_clk);
        n++;
      end
    end
    pulse_start();
    @(negedge ref_clk);
    chk(code <= 5'd25, "R8 no reload", int'(code), 25);
    wait_done("R8 done");
    @(negedge ref_clk);
    chk(code == 5'd20, "R8 result", int'(code), 20);

    // R1: reset in the middle of a search
    xsel = 3;
    pulse_start();
    repeat (1500) @(negedge ref_clk);
    rst_n = 1'b0;
    @(negedge ref_clk);
    chk(code == 5'd31, "R1 mid code", int'(code), 31);
    chk(done == 1'b0 && cal_err == 1'b0, "R1 mid flags", int'(done), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge ref_clk);
    pulse_start();
    wait_done("R3 done");
    @(negedge ref_clk);
    chk(code == 5'd3, "R3 after reset", int'(code), 3);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule